// File: doc/BRIEF.md
# Linked-List Hit Data Organizer

This block holds the full-resolution hits of one event and hands them back grouped by their coarse super-strip identifier. During the fill phase the producer presents one hit per cycle, made of a super-strip ID and a full-resolution payload. Each hit lands in the next free slot of a hit store. A bucket table indexed by super-strip ID keeps the first and last slot used by each ID. A per-slot link array threads together all slots that share an ID. Hits may arrive in any order and with any spread over the IDs. The only limit is a per-event hit budget.

During the retrieval phase, a consumer that has decoded a road presents a super-strip ID to one of several lookup ports. That port then walks the chain and streams every hit filed under the ID, one per cycle, in the order the hits arrived. A final-beat flag marks the last hit. An ID with no hits answers with a single empty beat. The hit and link storage is replicated, one copy for every two ports, so all ports can walk their chains at the same time.

An event clear forgets every bucket in one cycle. It does this by advancing an event generation number, not by wiping the storage.

Top module: `do_hit_organizer`

## Requirements
- R1: A lookup accepted on a port (lookup valid high while ready is high at a rising edge) produces its first hit on the next cycle. It then produces one hit per cycle, returning every hit stored under that ID in the current event, in arrival order, with the payload on that port's slice of `rd_hit`.
- R2: The final hit of a chain has `rd_last` = 1 and every earlier hit has `rd_last` = 0. `rd_valid` is low on the cycle after the final hit.
- R3: A lookup of an ID with no hits in the current event produces exactly one beat, on the cycle after acceptance, with `rd_valid`, `rd_empty` and `rd_last` all 1. `rd_valid` is low on the following cycle.
- R4: `lk_ready` of a port is 1 only while that port is idle: after reset, and from the cycle after its previous response ended. A lookup presented while ready is 0 is not taken, and no stream follows it.
- R5: An event clear (`ev_clr` = 1 at an edge) makes every ID read as empty, resets the hit budget and clears `overflow`. A write presented in the same cycle as the clear is discarded.
- R6: At most MAX_HITS hits are stored per event. A further write is dropped, it never appears in any lookup, and it sets `overflow`. `overflow` then stays set until the next event clear or reset.
- R7: All ports work independently and concurrently. Several ports may walk the same ID, or different IDs, in the same cycles, and each returns the full correct chain.
- R8: Hits written in an event never reappear after any number of event clears, including when the generation number wraps around to the value it had when they were written.
- R9: After reset, `rd_valid`, `rd_empty`, `rd_last` and `overflow` are 0 and every `lk_ready` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ev_clr | input | 1 | Event clear: forget all stored hits |
| wr_valid | input | 1 | Write strobe for one hit |
| wr_ssid | input | SSID_W | Super-strip ID of the written hit |
| wr_hit | input | HIT_W | Full-resolution payload of the written hit |
| overflow | output | 1 | Sticky flag: a hit was dropped in this event |
| lk_valid | input | NPORTS | Per-port lookup request |
| lk_ssid | input | NPORTS*SSID_W | Per-port ID to retrieve, port p at bits p*SSID_W upward |
| lk_ready | output | NPORTS | Per-port idle, lookup can be accepted |
| rd_valid | output | NPORTS | Per-port response beat valid |
| rd_hit | output | NPORTS*HIT_W | Per-port hit payload, port p at bits p*HIT_W upward |
| rd_last | output | NPORTS | Per-port final beat of the response |
| rd_empty | output | NPORTS | Per-port empty response beat |

## Verification
The bench interleaves writes to several IDs. It then checks that each chain returns exactly its own hits in arrival order. A design that walked links wrongly would mix IDs or reverse the order. The bench writes one hit past the budget and checks that the extra hit never shows up. A design with an off-by-one would store it or flag the overflow too early. It also writes during an event clear, which a careless priority would store. The bench checks that all ports can walk one chain at once, which breaks a design that shares a read port. It checks that a lookup offered to a busy port is not queued. It cycles the generation number through a full wrap, after which a design without a sweep would bring back hits from four events earlier.

// File: rtl/do_pkg.sv
package do_pkg;

    localparam int DO_SSID_W   = 6;
    localparam int DO_HIT_W    = 16;
    localparam int DO_MAX_HITS = 32;
    localparam int DO_NPORTS   = 4;
    localparam int DO_GEN_W    = 3;

    // Read-port sequencer states
    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_WALK  = 2'd1,
        RP_EMPTY = 2'd2
    } rp_state_e;

    // One storage copy serves two read ports
    function automatic int clones_for(input int nports);
        return (nports + 1) / 2;
    endfunction

endpackage

// File: rtl/do_head_table.sv
module do_head_table
    import do_pkg::*;
#(
    parameter int SSID_W = DO_SSID_W,
    parameter int ADDR_W = 5,
    parameter int GEN_W  = DO_GEN_W,
    parameter int NPORTS = DO_NPORTS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ev_clr,
    input  logic                              wr_en,
    input  logic [SSID_W-1:0]                 wr_ssid,
    input  logic [ADDR_W-1:0]                 wr_addr,
    output logic                              link_en,
    output logic [ADDR_W-1:0]                 link_from,
    input  logic [NPORTS-1:0][SSID_W-1:0]     q_ssid,
    output logic [NPORTS-1:0]                 q_live,
    output logic [NPORTS-1:0][ADDR_W-1:0]     q_head,
    output logic [NPORTS-1:0][ADDR_W-1:0]     q_tail
);
    localparam int NSS = 1 << SSID_W;

    typedef struct packed {
        logic              vld;
        logic [GEN_W-1:0]  tag;
        logic [ADDR_W-1:0] head;
        logic [ADDR_W-1:0] tail;
    } bucket_t;

    bucket_t          tbl [NSS];
    logic [GEN_W-1:0] gen;
    bucket_t          w_ent;
    logic             w_live;

    assign w_ent     = tbl[wr_ssid];
    assign w_live    = w_ent.vld && (w_ent.tag == gen);
    // Appending to a live bucket links the old tail to the new slot
    assign link_en   = wr_en && w_live;
    assign link_from = w_ent.tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen <= '0;
            for (int i = 0; i < NSS; i++) tbl[i].vld <= 1'b0;
        end else if (ev_clr) begin
            gen <= gen + 1'b1;
            // Sweep on wrap so an old tag can never match again
            if (&gen) begin
                for (int i = 0; i < NSS; i++) tbl[i].vld <= 1'b0;
            end
        end else if (wr_en) begin
            if (w_live) begin
                tbl[wr_ssid].tail <= wr_addr;
            end else begin
                tbl[wr_ssid] <= '{vld: 1'b1, tag: gen, head: wr_addr, tail: wr_addr};
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_query
        bucket_t q_ent;
        assign q_ent     = tbl[q_ssid[p]];
        assign q_live[p] = q_ent.vld && (q_ent.tag == gen);
        assign q_head[p] = q_ent.head;
        assign q_tail[p] = q_ent.tail;
    end

endmodule

// File: rtl/do_hit_store.sv
module do_hit_store
    import do_pkg::*;
#(
    parameter int HIT_W  = DO_HIT_W,
    parameter int ADDR_W = 5,
    parameter int DEPTH  = DO_MAX_HITS,
    parameter int NPORTS = DO_NPORTS
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [HIT_W-1:0]              wr_hit,
    input  logic                          link_en,
    input  logic [ADDR_W-1:0]             link_from,
    input  logic [NPORTS-1:0][ADDR_W-1:0] rd_addr,
    output logic [NPORTS-1:0][HIT_W-1:0]  rd_hit,
    output logic [NPORTS-1:0][ADDR_W-1:0] rd_next
);
    localparam int NCL = clones_for(NPORTS);

    for (genvar c = 0; c < NCL; c++) begin : g_clone
        logic [HIT_W-1:0]  hmem [DEPTH];
        logic [ADDR_W-1:0] nmem [DEPTH];

        // Every copy takes the same write so all copies stay identical
        always_ff @(posedge clk) begin
            if (wr_en)   hmem[wr_addr]   <= wr_hit;
            if (link_en) nmem[link_from] <= wr_addr;
        end

        for (genvar k = 0; k < 2; k++) begin : g_port
            localparam int P = 2 * c + k;
            if (P < NPORTS) begin : g_used
                assign rd_hit[P]  = hmem[rd_addr[P]];
                assign rd_next[P] = nmem[rd_addr[P]];
            end
        end
    end

endmodule

// File: rtl/do_read_port.sv
module do_read_port
    import do_pkg::*;
#(
    parameter int SSID_W = DO_SSID_W,
    parameter int ADDR_W = 5,
    parameter int HIT_W  = DO_HIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [SSID_W-1:0] lk_ssid,
    output logic              lk_ready,
    output logic [SSID_W-1:0] q_ssid,
    input  logic              q_live,
    input  logic [ADDR_W-1:0] q_head,
    input  logic [ADDR_W-1:0] q_tail,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [HIT_W-1:0]  mem_hit,
    input  logic [ADDR_W-1:0] mem_next,
    output logic              rd_valid,
    output logic [HIT_W-1:0]  rd_hit,
    output logic              rd_last,
    output logic              rd_empty
);
    rp_state_e         st;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] tail;
    logic              at_tail;

    assign lk_ready = (st == RP_IDLE);
    assign q_ssid   = lk_ssid;
    assign mem_addr = cur;
    assign at_tail  = (cur == tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RP_IDLE;
            cur  <= '0;
            tail <= '0;
        end else begin
            case (st)
                RP_IDLE: begin
                    if (lk_valid) begin
                        if (q_live) begin
                            st   <= RP_WALK;
                            cur  <= q_head;
                            tail <= q_tail;
                        end else begin
                            st <= RP_EMPTY;
                        end
                    end
                end
                RP_WALK: begin
                    if (at_tail) st  <= RP_IDLE;
                    else         cur <= mem_next;
                end
                RP_EMPTY: st <= RP_IDLE;
                default:  st <= RP_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_valid = (st != RP_IDLE);
        rd_empty = (st == RP_EMPTY);
        rd_last  = (st == RP_EMPTY) || ((st == RP_WALK) && at_tail);
        rd_hit   = (st == RP_WALK) ? mem_hit : '0;
    end

endmodule

// File: rtl/do_hit_organizer.sv
module do_hit_organizer
    import do_pkg::*;
#(
    parameter int SSID_W   = DO_SSID_W,
    parameter int HIT_W    = DO_HIT_W,
    parameter int MAX_HITS = DO_MAX_HITS,
    parameter int NPORTS   = DO_NPORTS,
    parameter int GEN_W    = DO_GEN_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ev_clr,
    input  logic                       wr_valid,
    input  logic [SSID_W-1:0]          wr_ssid,
    input  logic [HIT_W-1:0]           wr_hit,
    output logic                       overflow,
    input  logic [NPORTS-1:0]          lk_valid,
    input  logic [NPORTS*SSID_W-1:0]   lk_ssid,
    output logic [NPORTS-1:0]          lk_ready,
    output logic [NPORTS-1:0]          rd_valid,
    output logic [NPORTS*HIT_W-1:0]    rd_hit,
    output logic [NPORTS-1:0]          rd_last,
    output logic [NPORTS-1:0]          rd_empty
);
    localparam int ADDR_W = $clog2(MAX_HITS);
    localparam int CNT_W  = $clog2(MAX_HITS + 1);

    logic [CNT_W-1:0]                 cnt;
    logic                             room;
    logic                             wr_acc;
    logic [ADDR_W-1:0]                wr_addr;
    logic                             link_en;
    logic [ADDR_W-1:0]                link_from;
    logic [NPORTS-1:0][SSID_W-1:0]    lk_ssid_v;
    logic [NPORTS-1:0][SSID_W-1:0]    q_ssid;
    logic [NPORTS-1:0]                q_live;
    logic [NPORTS-1:0][ADDR_W-1:0]    q_head;
    logic [NPORTS-1:0][ADDR_W-1:0]    q_tail;
    logic [NPORTS-1:0][ADDR_W-1:0]    m_addr;
    logic [NPORTS-1:0][HIT_W-1:0]     m_hit;
    logic [NPORTS-1:0][ADDR_W-1:0]    m_next;
    logic [NPORTS-1:0][HIT_W-1:0]     rd_hit_v;

    assign lk_ssid_v = lk_ssid;
    assign rd_hit    = rd_hit_v;
    assign room      = (cnt < CNT_W'(MAX_HITS));
    assign wr_acc    = wr_valid && !ev_clr && room;
    assign wr_addr   = cnt[ADDR_W-1:0];

    // Per-event budget and sticky drop flag; clear wins over write
    always_ff @(posedge clk) begin
        if (rst || ev_clr) begin
            cnt      <= '0;
            overflow <= 1'b0;
        end else if (wr_valid) begin
            if (room) cnt      <= cnt + 1'b1;
            else      overflow <= 1'b1;
        end
    end

    do_head_table #(
        .SSID_W (SSID_W),
        .ADDR_W (ADDR_W),
        .GEN_W  (GEN_W),
        .NPORTS (NPORTS)
    ) u_head (
        .clk       (clk),
        .rst       (rst),
        .ev_clr    (ev_clr),
        .wr_en     (wr_acc),
        .wr_ssid   (wr_ssid),
        .wr_addr   (wr_addr),
        .link_en   (link_en),
        .link_from (link_from),
        .q_ssid    (q_ssid),
        .q_live    (q_live),
        .q_head    (q_head),
        .q_tail    (q_tail)
    );

    do_hit_store #(
        .HIT_W  (HIT_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (MAX_HITS),
        .NPORTS (NPORTS)
    ) u_store (
        .clk       (clk),
        .wr_en     (wr_acc),
        .wr_addr   (wr_addr),
        .wr_hit    (wr_hit),
        .link_en   (link_en),
        .link_from (link_from),
        .rd_addr   (m_addr),
        .rd_hit    (m_hit),
        .rd_next   (m_next)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        do_read_port #(
            .SSID_W (SSID_W),
            .ADDR_W (ADDR_W),
            .HIT_W  (HIT_W)
        ) u_rp (
            .clk      (clk),
            .rst      (rst),
            .lk_valid (lk_valid[p]),
            .lk_ssid  (lk_ssid_v[p]),
            .lk_ready (lk_ready[p]),
            .q_ssid   (q_ssid[p]),
            .q_live   (q_live[p]),
            .q_head   (q_head[p]),
            .q_tail   (q_tail[p]),
            .mem_addr (m_addr[p]),
            .mem_hit  (m_hit[p]),
            .mem_next (m_next[p]),
            .rd_valid (rd_valid[p]),
            .rd_hit   (rd_hit_v[p]),
            .rd_last  (rd_last[p]),
            .rd_empty (rd_empty[p])
        );
    end

endmodule

// File: rtl/do_checker.sv
module do_checker #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_clr,
    input logic              wr_valid,
    input logic              overflow,
    input logic [NPORTS-1:0] lk_valid,
    input logic [NPORTS-1:0] lk_ready,
    input logic [NPORTS-1:0] rd_valid,
    input logic [NPORTS-1:0] rd_last,
    input logic [NPORTS-1:0] rd_empty
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_p
        // R4: a port that is answering does not offer ready
        a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
            rd_valid[p] |-> !lk_ready[p]);
        // R1: an accepted lookup answers on the next cycle
        a_r1_answer_next: assert property (@(posedge clk) disable iff (rst)
            (lk_valid[p] && lk_ready[p]) |=> rd_valid[p]);
        // R3: empty beat is a single final beat
        a_r3_empty_is_last: assert property (@(posedge clk) disable iff (rst)
            rd_empty[p] |-> (rd_valid[p] && rd_last[p]));
        a_r3_empty_single: assert property (@(posedge clk) disable iff (rst)
            rd_empty[p] |=> !rd_valid[p]);
        // R2: nothing follows the final beat
        a_r2_last_ends: assert property (@(posedge clk) disable iff (rst)
            (rd_valid[p] && rd_last[p]) |=> !rd_valid[p]);
    end

    // R6: drop flag is sticky within an event
    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ev_clr) |=> overflow);
    // R6: drop flag rises only from a write
    a_r6_overflow_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(wr_valid));
    // R5: event clear removes the flag
    a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
        ev_clr |=> !overflow);

endmodule

bind do_hit_organizer do_checker #(.NPORTS(NPORTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_clr   (ev_clr),
    .wr_valid (wr_valid),
    .overflow (overflow),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .rd_empty (rd_empty)
);

// File: tb/tb_do_hit_organizer.sv
module tb_do_hit_organizer;
    localparam int SW = 4;
    localparam int HW = 12;
    localparam int MH = 8;
    localparam int NP = 4;
    localparam int NS = 1 << SW;

    // Write vectors {ssid, payload}: interleaved IDs, exactly MH of them
    localparam logic [15:0] WR_VEC [MH] = '{
        16'h3101, 16'h5202, 16'h3103, 16'h9404,
        16'h3105, 16'h5206, 16'h0307, 16'hF408
    };
    // Lookup vectors {ssid, expected hit count}
    localparam logic [7:0] LK_VEC [6] = '{
        8'h33, 8'h52, 8'h91, 8'h01, 8'hF1, 8'hC0
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 ev_clr = 1'b0;
    logic                 wr_valid = 1'b0;
    logic [SW-1:0]        wr_ssid = '0;
    logic [HW-1:0]        wr_hit = '0;
    logic                 overflow;
    logic [NP-1:0]        lk_valid;
    logic [NP*SW-1:0]     lk_ssid;
    logic [NP-1:0]        lk_ready;
    logic [NP-1:0]        rd_valid;
    logic [NP*HW-1:0]     rd_hit;
    logic [NP-1:0]        rd_last;
    logic [NP-1:0]        rd_empty;

    logic                 lk_v_a [NP];
    logic [SW-1:0]        lk_s_a [NP];

    int                   n_chk = 0;
    int                   n_fail = 0;
    bit                   done = 1'b0;

    int                   mdl_n [NS];
    logic [HW-1:0]        mdl_h [NS][MH];
    int                   mdl_tot = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            lk_valid[p]            = lk_v_a[p];
            lk_ssid[p*SW +: SW]    = lk_s_a[p];
        end
    end

    do_hit_organizer #(
        .SSID_W(SW), .HIT_W(HW), .MAX_HITS(MH), .NPORTS(NP), .GEN_W(2)
    ) dut (
        .clk(clk), .rst(rst), .ev_clr(ev_clr), .wr_valid(wr_valid),
        .wr_ssid(wr_ssid), .wr_hit(wr_hit), .overflow(overflow),
        .lk_valid(lk_valid), .lk_ssid(lk_ssid), .lk_ready(lk_ready),
        .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_last(rd_last),
        .rd_empty(rd_empty)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int s = 0; s < NS; s++) mdl_n[s] = 0;
        mdl_tot = 0;
    endtask

    task automatic do_write(input logic [SW-1:0] s, input logic [HW-1:0] h);
        @(negedge clk);
        wr_valid = 1'b1; wr_ssid = s; wr_hit = h;
        @(negedge clk);
        wr_valid = 1'b0;
        if (mdl_tot < MH) begin
            mdl_h[s][mdl_n[s]] = h;
            mdl_n[s]++;
            mdl_tot++;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        ev_clr = 1'b1;
        @(negedge clk);
        ev_clr = 1'b0;
        mdl_clear();
    endtask

    // Issue one lookup and check the whole response against the model
    task automatic do_lookup(input int p, input logic [SW-1:0] s, input int exp_n);
        @(negedge clk);
        chk(lk_ready[p] == 1'b1, "R4 ready when idle", lk_ready[p], 1);
        lk_v_a[p] = 1'b1; lk_s_a[p] = s;
        @(negedge clk);
        lk_v_a[p] = 1'b0;
        chk(mdl_n[s] == exp_n, "R1 hit count", mdl_n[s], exp_n);
        if (exp_n == 0) begin
            chk(rd_valid[p] && rd_empty[p] && rd_last[p], "R3 empty beat",
                {rd_valid[p], rd_empty[p], rd_last[p]}, 3'b111);
            @(negedge clk);
            chk(rd_valid[p] == 1'b0, "R3 single empty beat", rd_valid[p], 0);
        end else begin
            for (int k = 0; k < exp_n; k++) begin
                chk(rd_valid[p] == 1'b1 && rd_empty[p] == 1'b0, "R1 beat valid",
                    {rd_valid[p], rd_empty[p]}, 2'b10);
                chk(rd_hit[p*HW +: HW] == mdl_h[s][k], "R1 hit order",
                    rd_hit[p*HW +: HW], mdl_h[s][k]);
                chk(rd_last[p] == (k == exp_n - 1), "R2 last flag",
                    rd_last[p], (k == exp_n - 1));
                chk(lk_ready[p] == 1'b0, "R4 busy", lk_ready[p], 0);
                @(negedge clk);
            end
            chk(rd_valid[p] == 1'b0, "R2 stream ended", rd_valid[p], 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            lk_v_a[p] = 1'b0;
            lk_s_a[p] = '0;
        end
        mdl_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk(rd_valid == '0 && rd_empty == '0 && rd_last == '0, "R9 outputs idle",
            {rd_valid, rd_empty, rd_last}, 0);
        chk(lk_ready == '1, "R9 all ready", lk_ready, {NP{1'b1}});
        chk(overflow == 1'b0, "R9 overflow clear", overflow, 0);

        // Fill the event exactly to its budget
        for (int i = 0; i < MH; i++) do_write(WR_VEC[i][15:12], WR_VEC[i][HW-1:0]);
        chk(overflow == 1'b0, "R6 no overflow at budget", overflow, 0);

        // R6: writes beyond the budget are dropped and flagged
        do_write(4'h3, 12'h999);
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        do_write(4'h7, 12'h777);
        chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);
        do_lookup(0, 4'h7, 0);

        // R1/R2/R3: table of lookups spread over the ports
        for (int i = 0; i < 6; i++) do_lookup(i % NP, LK_VEC[i][7:4], int'(LK_VEC[i][3:0]));

        // R7: all ports walk the same chain together
        for (int p = 0; p < NP; p++) begin
            automatic int q = p;
            fork
                do_lookup(q, 4'h3, 3);
            join_none
        end
        wait fork;

        // R7: different IDs on all ports together
        fork
            do_lookup(0, 4'h5, 2);
            do_lookup(1, 4'h3, 3);
            do_lookup(2, 4'hC, 0);
            do_lookup(3, 4'h9, 1);
        join

        // R4: a lookup offered to a busy port is not taken
        @(negedge clk);
        lk_v_a[0] = 1'b1; lk_s_a[0] = 4'h3;
        @(negedge clk);
        lk_s_a[0] = 4'h5;
        chk(lk_ready[0] == 1'b0, "R4 busy not ready", lk_ready[0], 0);
        @(negedge clk);
        lk_v_a[0] = 1'b0;
        @(negedge clk);
        chk(rd_valid[0] && rd_last[0], "R4 original stream ends", {rd_valid[0], rd_last[0]}, 2'b11);
        @(negedge clk);
        chk(rd_valid[0] == 1'b0, "R4 busy request not queued", rd_valid[0], 0);
        @(negedge clk);
        chk(rd_valid[0] == 1'b0, "R4 busy request not queued later", rd_valid[0], 0);

        // R5: clear with a simultaneous write
        @(negedge clk);
        ev_clr = 1'b1; wr_valid = 1'b1; wr_ssid = 4'h3; wr_hit = 12'hABC;
        @(negedge clk);
        ev_clr = 1'b0; wr_valid = 1'b0;
        mdl_clear();
        chk(overflow == 1'b0, "R5 overflow cleared", overflow, 0);
        do_lookup(1, 4'h3, 0);
        do_lookup(2, 4'h5, 0);

        // R5: fresh event stores normally, full budget again
        do_write(4'h2, 12'h222);
        do_lookup(3, 4'h2, 1);
        for (int i = 1; i < MH; i++) do_write(4'h4, 12'(i));
        chk(overflow == 1'b0, "R5 budget restored", overflow, 0);
        do_lookup(0, 4'h4, MH - 1);

        // R8: stale entries stay dead across a full generation wrap
        do_write(4'h6, 12'h666);
        do_clear();
        do_clear();
        do_clear();
        do_clear();
        do_lookup(1, 4'h6, 0);
        do_lookup(2, 4'h4, 0);
        do_write(4'h6, 12'h606);
        do_lookup(3, 4'h6, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule